// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block interprets the multi-cycle command protocol of a parallel NOR flash on the slave side of a simple bus. Bus writes carry an address, data and an access size. The first write of a sequence is an opcode taken from the low data byte. That opcode decides how many more writes follow and which value confirms or aborts the sequence. The block keeps a command register, a write-cycle counter, a sticky status byte and a buffered-program count. It applies programs and sector erases to a small internal byte array that is sized by parameters.

Reads are registered and return one of four things, depending on the active command. These are array bytes in little-endian order, the status byte replicated across device lanes, or data from an external formatter for identification and query reads. The block tells that formatter which kind of read is active. A read-only strap blocks every change to the array and records the refusal in the status byte.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode (`rd_mode` = 0), the cycle counter is 0, the status byte is 0x80, and every array byte reads 0xFF.
- R2: In cycle 0 the opcode is `wdata[7:0]`. Opcodes 0x00, 0xF0 and 0xFF select array-read mode with no error. An opcode that is not listed in R2 to R8 selects array-read mode and raises `seq_err` for one cycle, in the cycle after the write.
- R3: Opcode 0x10 or 0x40 arms a program. The next write stores its low `size` bytes, little-endian, starting at its address (wrapping within the array). That write then ends the sequence and sets status bit 7, and reads return status until the next opcode.
- R4: Opcode 0x20 fills the whole sector that holds the address (2^SECT_W bytes, aligned down) with 0xFF when the opcode itself is written, and sets status bit 7. In the next write, 0xD0 confirms, 0xFF returns to array read with no error, and any other value returns to array read and raises `seq_err`.
- R5: Opcode 0x50 clears all status bits and selects array read. Opcode 0x70 selects status reads and opcode 0x90 selects identification reads. Neither 0x70 nor 0x90 advances the cycle counter, so the next write is decoded as a new opcode.
- R6: Opcode 0x60 waits for one more write. A value of 0xD0 or 0x01 completes it and sets status bit 7, leaving status reads active. Any other value selects array read with no error.
- R7: Opcode 0x98 selects query reads (`rd_mode` = 3). A later 0xFF returns to array read, and any other write leaves query mode unchanged.
- R8: Opcode 0xE8 sets status bit 7. The next write gives a count N, masked to the low 8*DEV_BYTES bits. Then N+1 data writes follow, each programming like R3. A write of 0xD0 after them finishes with status bit 7 set, and any other value selects array read with no error.
- R9: While the command is 0x10, 0x20, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte in byte lane 0. It also returns the status byte in each lane i that is a multiple of DEV_BYTES with i+DEV_BYTES not beyond the access size. All other lanes read 0.
- R10: With `ro_strap` high, the array never changes. A refused program or buffered data write sets status bit 4 (0x10), a refused erase sets status bit 5 (0x20), and status bit 7 is still set.
- R11: A read asserts `rvalid` and updates `rdata` exactly one cycle after `rd_en`. The access size is encoded as 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, and unused upper bytes read 0. A read in the same cycle as a write reflects the mode and the array as they were before that write.
- R12: `rd_mode` reports the read source from the current command (0 array, 1 status, 2 identification, 3 query). In modes 2 and 3 the registered read data is `info_data`, sampled with the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address for the read or write |
| wdata | input | 32 | Write data; opcode in the low byte |
| size | input | 2 | Access size: 0 = 1, 1 = 2, 2/3 = 4 bytes |
| ro_strap | input | 1 | Array is read-only when high |
| info_data | input | 32 | Identification/query data from the external formatter |
| rd_mode | output | 2 | Current read source (R12 encoding) |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| seq_err | output | 1 | One-cycle pulse after a rejected command write |

## Verification
A read and a write can be accepted on the same edge, and that edge may also move the block out of array mode or erase the sector being read. The bench creates this case with an erase opcode that it writes while reading the same address in array mode. It expects the read to return the bytes from before the erase. Later reads must return the status byte first and then 0xFF across the whole sector, and a byte just outside the sector must keep its value.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] OP_IDLE      = 8'h00;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERASE_ALT = 8'h28;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLEAR     = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_BUFPROG   = 8'hE8;
  localparam logic [7:0] OP_EXIT_ALT  = 8'hF0;
  localparam logic [7:0] OP_EXIT      = 8'hFF;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;

  localparam logic [7:0] ST_READY     = 8'h80;
  localparam logic [7:0] ST_ERASE_ERR = 8'h20;
  localparam logic [7:0] ST_PROG_ERR  = 8'h10;

  // access size code to byte count
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // lane carries a status copy for the given access size and device width
  function automatic logic lane_live(input int lane, input logic [2:0] nb, input int dev);
    if (lane == 0) return 1'b1;
    return ((lane % dev) == 0) && ((lane + dev) <= int'(nb));
  endfunction

  function automatic rd_mode_e mode_of(input logic [7:0] cmd);
    case (cmd)
      OP_PROG_A, OP_ERASE, OP_ERASE_ALT, OP_PROG_B,
      OP_CLEAR, OP_LOCK, OP_STATUS, OP_BUFPROG: return RM_STATUS;
      OP_IDENT: return RM_IDENT;
      OP_QUERY: return RM_QUERY;
      default:  return RM_ARRAY;
    endcase
  endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_seq_pkg::*;
#(
  parameter int DEV_BYTES = 1,
  localparam int CNT_W = 8 * DEV_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  input  logic             ro_strap,
  output logic [7:0]       cmd_q,
  output logic [1:0]       cyc_q,
  output logic [7:0]       status_q,
  output logic             prog_we,
  output logic             erase_we,
  output logic             seq_err
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       cmd_d, status_d;
  logic [1:0]       cyc_d;
  logic             err_d;
  logic [7:0]       op;

  assign op = wdata[7:0];

  always_comb begin
    cmd_d    = cmd_q;
    cyc_d    = cyc_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    prog_we  = 1'b0;
    erase_we = 1'b0;
    err_d    = 1'b0;
    if (wr_en) begin
      case (cyc_q)
        2'd0: begin
          case (op)
            OP_IDLE, OP_EXIT_ALT, OP_EXIT: cmd_d = OP_IDLE;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_d = op;
              cyc_d = 2'd1;
            end
            OP_ERASE: begin
              erase_we = !ro_strap;
              if (ro_strap) status_d = status_d | ST_ERASE_ERR;
              status_d = status_d | ST_READY;
              cmd_d    = op;
              cyc_d    = 2'd1;
            end
            OP_CLEAR: begin
              status_d = 8'h00;
              cmd_d    = OP_IDLE;
            end
            OP_STATUS, OP_IDENT: cmd_d = op;
            OP_BUFPROG: begin
              status_d = status_d | ST_READY;
              cmd_d    = op;
              cyc_d    = 2'd1;
            end
            default: begin
              err_d = 1'b1;
              cmd_d = OP_IDLE;
            end
          endcase
        end
        2'd1: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              prog_we = !ro_strap;
              if (ro_strap) status_d = status_d | ST_PROG_ERR;
              status_d = status_d | ST_READY;
              cyc_d    = 2'd0;
            end
            OP_ERASE, OP_ERASE_ALT: begin
              cyc_d = 2'd0;
              if (op == OP_CONFIRM) begin
                status_d = status_d | ST_READY;
              end else begin
                cmd_d = OP_IDLE;
                err_d = (op != OP_EXIT);
              end
            end
            OP_BUFPROG: begin
              cnt_d = wdata;
              cyc_d = 2'd2;
            end
            OP_LOCK: begin
              cyc_d = 2'd0;
              if (op == OP_CONFIRM || op == OP_LOCK_ALT) status_d = status_d | ST_READY;
              else cmd_d = OP_IDLE;
            end
            OP_QUERY: begin
              if (op == OP_EXIT) begin
                cyc_d = 2'd0;
                cmd_d = OP_IDLE;
              end
            end
            default: begin
              err_d = 1'b1;
              cyc_d = 2'd0;
              cmd_d = OP_IDLE;
            end
          endcase
        end
        2'd2: begin
          if (cmd_q == OP_BUFPROG) begin
            prog_we = !ro_strap;
            if (ro_strap) status_d = status_d | ST_PROG_ERR;
            status_d = status_d | ST_READY;
            if (cnt_q == '0) cyc_d = 2'd3;
            cnt_d = cnt_q - CNT_W'(1);
          end else begin
            err_d = 1'b1;
            cyc_d = 2'd0;
            cmd_d = OP_IDLE;
          end
        end
        default: begin
          cyc_d = 2'd0;
          if (cmd_q == OP_BUFPROG && op == OP_CONFIRM) begin
            status_d = status_d | ST_READY;
          end else begin
            cmd_d = OP_IDLE;
            err_d = (cmd_q != OP_BUFPROG);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= OP_IDLE;
      cyc_q    <= 2'd0;
      status_q <= ST_READY;
      cnt_q    <= '0;
      seq_err  <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      cyc_q    <= cyc_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
      seq_err  <= err_d;
    end
  end

  // R8
  bufcnt_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == 2'd2 && cnt_q == '0) |=> (cyc_q == 2'd3));

  // R8
  deep_cycle_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_q[1] |-> (cmd_q == OP_BUFPROG));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == 2'd0 && wdata[7:0] == OP_CLEAR) |=> (status_q == 8'h00 && cmd_q == OP_IDLE));

  // R10
  ro_prog_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ro_strap && cyc_q == 2'd1 && (cmd_q == OP_PROG_A || cmd_q == OP_PROG_B))
      |=> (status_q[4] && status_q[7]));

  // R2
  err_lands_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |-> (cmd_q == OP_IDLE && cyc_q == 2'd0));

endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 5,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int SECT_BYTES = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic              erase_we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [2:0]        nbytes,
  output logic [31:0]       rd_word
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[ADDR_W'(i)] <= 8'hFF;
    end else begin
      if (erase_we) begin
        for (int i = 0; i < SECT_BYTES; i++)
          mem[{addr[ADDR_W-1:SECT_W], SECT_W'(i)}] <= 8'hFF;
      end
      if (prog_we) begin
        for (int k = 0; k < 4; k++)
          if (k < int'(nbytes)) mem[addr + ADDR_W'(k)] <= wdata[k*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(nbytes)) rd_word[k*8 +: 8] = mem[addr + ADDR_W'(k)];
  end

  // R4
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (mem[{$past(addr[ADDR_W-1:SECT_W]), SECT_W'(0)}] == 8'hFF));

  // R3
  prog_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_we |=> (mem[$past(addr)] == $past(wdata[7:0])));

endmodule

// File: rtl/nor_read_path.sv
module nor_read_path
  import nor_seq_pkg::*;
#(
  parameter int DEV_BYTES = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  rd_mode_e    mode,
  input  logic [7:0]  status,
  input  logic [2:0]  nbytes,
  input  logic [31:0] array_word,
  input  logic [31:0] info_data,
  output logic [31:0] rdata,
  output logic        rvalid
);

  logic [31:0] stat_word;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign stat_word[g*8 +: 8] = lane_live(g, nbytes, DEV_BYTES) ? status : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        case (mode)
          RM_STATUS:          rdata <= stat_word;
          RM_IDENT, RM_QUERY: rdata <= info_data;
          default:            rdata <= array_word;
        endcase
      end
    end
  end

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  // R11
  rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 5,
  parameter int DEV_BYTES = 1,
  localparam int CNT_W    = 8 * DEV_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [1:0]        size,
  input  logic              ro_strap,
  input  logic [31:0]       info_data,
  output logic [1:0]        rd_mode,
  output logic [31:0]       rdata,
  output logic              rvalid,
  output logic              seq_err
);

  logic [7:0]  cmd_q, status_q;
  logic [1:0]  cyc_q;
  logic        prog_we, erase_we;
  logic [2:0]  nbytes;
  logic [31:0] array_word;
  rd_mode_e    mode;

  assign nbytes  = size_bytes(size);
  assign mode    = mode_of(cmd_q);
  assign rd_mode = mode;

  nor_cmd_fsm #(.DEV_BYTES(DEV_BYTES)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wdata    (wdata[CNT_W-1:0]),
    .ro_strap (ro_strap),
    .cmd_q    (cmd_q),
    .cyc_q    (cyc_q),
    .status_q (status_q),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .seq_err  (seq_err)
  );

  nor_byte_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_we  (prog_we),
    .erase_we (erase_we),
    .addr     (addr),
    .wdata    (wdata),
    .nbytes   (nbytes),
    .rd_word  (array_word)
  );

  nor_read_path #(.DEV_BYTES(DEV_BYTES)) u_read (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_en      (rd_en),
    .mode       (mode),
    .status     (status_q),
    .nbytes     (nbytes),
    .array_word (array_word),
    .info_data  (info_data),
    .rdata      (rdata),
    .rvalid     (rvalid)
  );

  // R10
  ro_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ro_strap |-> !(prog_we || erase_we));

  // R6
  lock_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cyc_q == 2'd1 && cmd_q == OP_LOCK && (wdata[7:0] == OP_CONFIRM || wdata[7:0] == OP_LOCK_ALT))
      |=> (rd_mode == RM_STATUS && status_q[7]));

  // R7
  query_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_mode == RM_QUERY && wdata[7:0] != OP_EXIT) |=> (rd_mode == RM_QUERY));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0]  size = '0;
  logic        ro_strap = 1'b0;
  logic [31:0] info_data;
  logic [1:0]  rd_mode;
  logic [31:0] rdata;
  logic        rvalid;
  logic        seq_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side model
  logic [7:0] shadow [256];
  logic [7:0] m_cmd = 8'h00;
  int         m_cyc = 0;
  logic [7:0] m_stat = 8'h80;
  int         m_cnt = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // formatter stand-in: mode and address visible in the returned word
  assign info_data = {22'h0, rd_mode, addr};

  nor_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .size(size), .ro_strap(ro_strap), .info_data(info_data),
    .rd_mode(rd_mode), .rdata(rdata), .rvalid(rvalid), .seq_err(seq_err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read words as results appear
  always @(negedge clk) begin
    if (rvalid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata === e, t, rdata, e);
      end
    end
  end

  function automatic int nb_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] r;
    int n;
    r = '0;
    n = nb_of(sz);
    if (m_cmd inside {8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8}) begin
      for (int i = 0; i < n; i++) r[i*8 +: 8] = m_stat;
    end else if (m_cmd == 8'h90) begin
      r = {22'h0, 2'b10, a};
    end else if (m_cmd == 8'h98) begin
      r = {22'h0, 2'b11, a};
    end else begin
      for (int i = 0; i < n; i++) r[i*8 +: 8] = shadow[8'(a + 8'(i))];
    end
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz, output bit err);
    logic [7:0] c;
    c = d[7:0];
    err = 1'b0;
    if (m_cyc == 0) begin
      if (c inside {8'h00, 8'hF0, 8'hFF}) m_cmd = 8'h00;
      else if (c inside {8'h10, 8'h40, 8'h60, 8'h98}) begin m_cmd = c; m_cyc = 1; end
      else if (c == 8'h20) begin
        if (ro_strap) m_stat |= 8'h20;
        else for (int j = 0; j < 32; j++) shadow[{a[7:5], 5'(j)}] = 8'hFF;
        m_stat |= 8'h80; m_cmd = c; m_cyc = 1;
      end
      else if (c == 8'h50) begin m_stat = 8'h00; m_cmd = 8'h00; end
      else if (c inside {8'h70, 8'h90}) m_cmd = c;
      else if (c == 8'hE8) begin m_stat |= 8'h80; m_cmd = c; m_cyc = 1; end
      else begin err = 1'b1; m_cmd = 8'h00; end
    end else if (m_cyc == 1) begin
      case (m_cmd)
        8'h10, 8'h40: begin
          if (ro_strap) m_stat |= 8'h10;
          else for (int k = 0; k < nb_of(sz); k++) shadow[8'(a + 8'(k))] = d[k*8 +: 8];
          m_stat |= 8'h80; m_cyc = 0;
        end
        8'h20: begin
          m_cyc = 0;
          if (c == 8'hD0) m_stat |= 8'h80;
          else begin m_cmd = 8'h00; err = (c != 8'hFF); end
        end
        8'hE8: begin m_cnt = int'(c); m_cyc = 2; end
        8'h60: begin
          m_cyc = 0;
          if (c == 8'hD0 || c == 8'h01) m_stat |= 8'h80; else m_cmd = 8'h00;
        end
        default: if (c == 8'hFF) begin m_cyc = 0; m_cmd = 8'h00; end
      endcase
    end else if (m_cyc == 2) begin
      if (ro_strap) m_stat |= 8'h10;
      else for (int k = 0; k < nb_of(sz); k++) shadow[8'(a + 8'(k))] = d[k*8 +: 8];
      m_stat |= 8'h80;
      if (m_cnt == 0) m_cyc = 3;
      m_cnt = (m_cnt - 1) & 8'hFF;
    end else begin
      m_cyc = 0;
      if (c == 8'hD0) m_stat |= 8'h80; else m_cmd = 8'h00;
    end
  endtask

  // driver: one bus cycle, optional write and optional read
  task automatic bus(input bit w, input bit r, input logic [7:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input string tag);
    bit e;
    e = 1'b0;
    @(negedge clk);
    addr = a; wdata = d; size = sz; wr_en = w; rd_en = r;
    if (r) begin
      exp_q.push_back(model_read(a, sz));
      tag_q.push_back(tag);
    end
    if (w) model_write(a, d, sz, e);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (w) check(seq_err === e, {"R2 seq_err after ", tag}, {31'h0, seq_err}, {31'h0, e});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz, input string tag);
    bus(1'b1, 1'b0, a, d, sz, tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, input string tag);
    bus(1'b0, 1'b1, a, 32'h0, sz, tag);
  endtask

  task automatic chk_mode(input logic [1:0] exp, input string tag);
    @(negedge clk);
    check(rd_mode === exp, tag, {30'h0, rd_mode}, {30'h0, exp});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(rd_mode === 2'd0 && rvalid === 1'b0, "R1 reset mode/rvalid", {30'h0, rd_mode}, 32'h0);
    rd(8'h00, 2'd2, "R1 erased array after reset");
    wr(8'h00, 32'h70, 2'd2, "R5 status opcode");
    chk_mode(2'd1, "R5 status mode");
    rd(8'h00, 2'd2, "R1 R9 ready status 4 lanes");
    rd(8'h00, 2'd1, "R9 status 2 lanes");
    rd(8'h00, 2'd0, "R9 status 1 lane");

    // R3 program word, then a wrapping byte
    wr(8'h10, 32'h40, 2'd0, "R3 arm program");
    wr(8'h10, 32'h11223344, 2'd2, "R3 program word");
    rd(8'h10, 2'd2, "R3 status after program");
    wr(8'h00, 32'hFF, 2'd0, "R2 exit");
    rd(8'h10, 2'd2, "R3 R11 word readback");
    rd(8'h12, 2'd1, "R11 half readback");
    wr(8'h00, 32'h10, 2'd0, "R3 arm program alt");
    wr(8'hFF, 32'hCCDDEEAB, 2'd0, "R3 program byte");
    wr(8'h00, 32'hF0, 2'd0, "R2 alt exit");
    rd(8'hFF, 2'd2, "R11 wrap read");
    wr(8'h00, 32'h40, 2'd0, "R3 arm");
    wr(8'h20, 32'h5A, 2'd0, "R3 byte in next sector");
    wr(8'h00, 32'hFF, 2'd0, "R2 exit");

    // R4 erase opcode concurrent with an array read of the same address
    bus(1'b1, 1'b1, 8'h13, 32'h20, 2'd2, "R11 R4 read beside erase");
    rd(8'h13, 2'd2, "R4 status after erase");
    wr(8'h13, 32'hD0, 2'd0, "R4 confirm");
    wr(8'h00, 32'hFF, 2'd0, "R2 exit");
    rd(8'h10, 2'd2, "R4 sector erased");
    rd(8'h1C, 2'd2, "R4 sector top erased");
    rd(8'h20, 2'd0, "R4 next sector kept");
    wr(8'h40, 32'h20, 2'd0, "R4 erase");
    wr(8'h40, 32'h33, 2'd0, "R4 bad confirm error");
    chk_mode(2'd0, "R4 array after bad confirm");
    wr(8'h40, 32'h20, 2'd0, "R4 erase");
    wr(8'h40, 32'hFF, 2'd0, "R4 exit without error");
    chk_mode(2'd0, "R4 array after exit");
    wr(8'h00, 32'h33, 2'd0, "R2 unknown opcode");
    chk_mode(2'd0, "R2 array after unknown");

    // R10 read-only strap
    @(negedge clk);
    ro_strap = 1'b1;
    wr(8'h30, 32'h40, 2'd0, "R10 arm program");
    wr(8'h30, 32'h77, 2'd0, "R10 refused program");
    rd(8'h30, 2'd2, "R10 prog error status");
    wr(8'h30, 32'h20, 2'd0, "R10 refused erase");
    wr(8'h30, 32'hD0, 2'd0, "R10 confirm");
    rd(8'h30, 2'd0, "R10 erase error status");
    wr(8'h30, 32'hE8, 2'd0, "R10 buffered");
    wr(8'h30, 32'h00, 2'd0, "R10 count zero");
    wr(8'h30, 32'h99, 2'd0, "R10 refused data");
    wr(8'h30, 32'hD0, 2'd0, "R10 buffered confirm");
    wr(8'h00, 32'hFF, 2'd0, "R2 exit");
    rd(8'h30, 2'd2, "R10 array unchanged");
    rd(8'h20, 2'd0, "R10 array unchanged 2");
    @(negedge clk);
    ro_strap = 1'b0;

    // R5 clear, ID mode then a new opcode straight away
    wr(8'h00, 32'h50, 2'd0, "R5 clear");
    chk_mode(2'd0, "R5 array after clear");
    wr(8'h00, 32'h70, 2'd0, "R5 status");
    rd(8'h00, 2'd2, "R5 cleared status");
    wr(8'h00, 32'h90, 2'd0, "R5 ident");
    chk_mode(2'd2, "R5 R12 ident mode");
    rd(8'h01, 2'd1, "R12 ident data");
    wr(8'h00, 32'h70, 2'd0, "R5 opcode from ident");
    chk_mode(2'd1, "R5 status after ident");

    // R6 lock
    wr(8'h00, 32'h60, 2'd0, "R6 lock");
    wr(8'h00, 32'h01, 2'd0, "R6 lock alt complete");
    rd(8'h00, 2'd2, "R6 ready after lock");
    wr(8'h00, 32'h60, 2'd0, "R6 lock");
    wr(8'h00, 32'hD0, 2'd0, "R6 lock confirm");
    chk_mode(2'd1, "R6 status after confirm");
    wr(8'h00, 32'h60, 2'd0, "R6 lock");
    wr(8'h00, 32'h55, 2'd0, "R6 other value");
    chk_mode(2'd0, "R6 array after other");

    // R7 query
    wr(8'h55, 32'h98, 2'd0, "R7 query");
    chk_mode(2'd3, "R7 query mode");
    rd(8'h20, 2'd2, "R7 R12 query data");
    wr(8'h00, 32'h12, 2'd0, "R7 stays in query");
    chk_mode(2'd3, "R7 query kept");
    wr(8'h00, 32'hFF, 2'd0, "R7 leave query");
    chk_mode(2'd0, "R7 array after leave");

    // R8 buffered program, count masked to one byte (0x0102 -> 2)
    wr(8'h80, 32'hE8, 2'd0, "R8 buffered");
    wr(8'h80, 32'h0102, 2'd1, "R8 masked count");
    wr(8'h80, 32'hA1, 2'd0, "R8 data 0");
    wr(8'h81, 32'hB2, 2'd0, "R8 data 1");
    wr(8'h82, 32'hC3, 2'd0, "R8 data 2");
    wr(8'h00, 32'hD0, 2'd0, "R8 confirm");
    rd(8'h00, 2'd2, "R8 status after confirm");
    wr(8'h00, 32'hFF, 2'd0, "R2 exit");
    rd(8'h80, 2'd2, "R8 buffered data");
    rd(8'h00, 2'd0, "R8 confirm not stored");
    wr(8'h90, 32'hE8, 2'd0, "R8 buffered");
    wr(8'h90, 32'h00, 2'd0, "R8 count zero");
    wr(8'h90, 32'h77, 2'd0, "R8 single data");
    wr(8'h00, 32'h44, 2'd0, "R8 abort at confirm");
    chk_mode(2'd0, "R8 array after abort");
    rd(8'h90, 2'd0, "R8 data kept after abort");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(1'b0, "R11 missing read results", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule